// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter with Update Hold-Off

This block keeps the seconds count of a real-time clock in BCD (00 to 59). A slow tick enable derived from a 32768 Hz oscillator drives an internal prescaler. Once per second the prescaler produces a carry, and the block then advances the seconds by one. Every update runs inside a busy window that is measured in ticks, and the busy flag stays high for the whole window. The host reads this flag to find out when the counter can safely be written.

The host can set a write-enable control bit to 0 to hold off updates while it reads or writes the counter. A carry that arrives during the hold is remembered, but only one is kept. The increment is applied as soon as updates are allowed again. Dropping the chip-enable input always re-enables updates. The host can also request a round-to-minute adjustment. This adjustment clears the seconds, and it issues a minute carry when the seconds were 30 or more.

A sticky oscillator-stop flag records that the oscillator halted while the chip was deselected. Writing the control register clears the flag, provided the oscillator is running at the time.

Top module: `rtc_sec_keeper`

## Requirements
- R1: The seconds advance by one BCD step for every PRESCALE accepted ticks. After 59 they wrap to 00, and min_carry_o is high for exactly the one clock cycle in which sec_o first shows 00.
- R2: A per-second increment holds busy_o high for exactly CARRY_TICKS ticks (default 3). The new value is visible on sec_o in the same cycle in which busy_o falls.
- R3: A write to address 0xE with data bit 0 set starts an adjustment. busy_o stays high for exactly ADJ_TICKS ticks (default 4), and then sec_o becomes 00. min_carry_o pulses once only when the earlier value was 30 or more.
- R4: When the write-enable bit (wten_o) is 0, a second carry is saved and does not change sec_o. When wten_o returns to 1, busy_o rises on the next clock and one increment follows.
- R5: At most one saved carry is kept, however many seconds pass while wten_o is 0.
- R6: A write to address 0xE loads wten_o from data bit 1. While ce_i is low, wten_o is forced to 1.
- R7: While ce_i is low and osc_run_i is low, osc_stop_o is set to 1. It stays 1 after the oscillator restarts.
- R8: While ce_i is high, osc_stop_o ignores osc_run_i.
- R9: A write to address 0xE clears osc_stop_o only when osc_run_i is 1.
- R10: A write to address 0x0 loads sec_o only while busy_o is 0. Otherwise it is ignored.
- R11: Writes made while ce_i is low have no effect.
- R12: After reset, sec_o is 00, busy_o is 0, wten_o is 1 and osc_stop_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the 32768 Hz rate |
| osc_run_i | input | 1 | 1 while the oscillator runs |
| ce_i | input | 1 | Chip enable; low deselects the chip |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Write address (0x0 seconds, 0xE control) |
| wdata_i | input | 8 | Write data (control: bit 0 adjust, bit 1 write-enable) |
| sec_o | output | 8 | Seconds in BCD |
| busy_o | output | 1 | Update window in progress |
| wten_o | output | 1 | Write-enable bit (1 = updates allowed) |
| osc_stop_o | output | 1 | Sticky oscillator-stop flag |
| min_carry_o | output | 1 | One-cycle pulse on minute rollover |

## Verification
The assertions assume that the host writes only valid BCD seconds values (tens 0 to 5, units 0 to 9). They also assume that ticks are spaced widely enough that a busy window ends before the next second's carry is due. The bench keeps within both assumptions. It drives a tick every second clock with a prescaler of eight ticks, and it writes only values built from integers 0 to 59. Each host write is placed just after a busy window has closed, so that it always falls well clear of the next carry.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_STEP = 2'd1,
    UPD_ADJ  = 2'd2
  } upd_kind_e;

  localparam logic [3:0] ADDR_SEC  = 4'h0;
  localparam logic [3:0] ADDR_CTRL = 4'hE;
  localparam int unsigned CTRL_ADJ_BIT  = 0;
  localparam int unsigned CTRL_WTEN_BIT = 1;

  // 59 is the last value before the wrap
  function automatic logic bcd_sec_at_top(input logic [7:0] s);
    return (s[7:4] >= 4'd5) && (s[3:0] >= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_sec_next(input logic [7:0] s);
    logic [7:0] r;
    if (s[3:0] >= 4'd9) begin
      if (s[7:4] >= 4'd5) r = 8'h00;
      else                r = {s[7:4] + 4'd1, 4'd0};
    end else begin
      r = {s[7:4], s[3:0] + 4'd1};
    end
    return r;
  endfunction

  // rounding to the nearest minute carries from 30 upward
  function automatic logic bcd_sec_rounds_up(input logic [7:0] s);
    return s[7:4] >= 4'd3;
  endfunction

endpackage

// File: rtl/rtc_sec_prescale.sv
module rtc_sec_prescale #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic sec_evt_o
);
  localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_evt_o = tick_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + PW'(1);
    end
  end

  // R1: the count never passes its terminal value
  a_r1_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/rtc_sec_ctrl.sv
module rtc_sec_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic osc_run_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_wten_i,
  output logic wten_o,
  output logic osc_stop_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wten_o     <= 1'b1;
      osc_stop_o <= 1'b1;
    end else if (!ce_i) begin
      wten_o <= 1'b1;
      if (!osc_run_i) osc_stop_o <= 1'b1;
    end else if (ctrl_wr_i) begin
      wten_o <= ctrl_wten_i;
      if (osc_run_i) osc_stop_o <= 1'b0;
    end
  end

  // R6: deselecting the chip re-enables updates
  a_r6_ce_low_wten: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> wten_o);

  // R7: stop flag only leaves 1 through a control write
  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop_o && !ctrl_wr_i) |=> osc_stop_o);

  // R8 and R9: with the chip selected the flag moves only on a write with the oscillator running
  a_r8_selected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && !(ctrl_wr_i && osc_run_i)) |=> $stable(osc_stop_o));

endmodule

// File: rtl/rtc_sec_seq.sv
module rtc_sec_seq
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CARRY_TICKS = 3,
  parameter int unsigned ADJ_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sec_evt_i,
  input  logic wten_i,
  input  logic adj_req_i,
  output logic busy_o,
  output logic step_o,
  output logic adj_o
);
  localparam int unsigned MAXT = (ADJ_TICKS > CARRY_TICKS) ? ADJ_TICKS : CARRY_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic          carry_pend_q;
  logic          adj_pend_q;
  upd_kind_e     kind_q;
  logic [CW-1:0] left_q;
  logic          finish;
  logic          start_adj;
  logic          start_step;

  assign finish     = busy_o && tick_i && (left_q == CW'(1));
  assign step_o     = finish && (kind_q == UPD_STEP);
  assign adj_o      = finish && (kind_q == UPD_ADJ);
  assign start_adj  = !busy_o && adj_pend_q;
  assign start_step = !busy_o && !adj_pend_q && carry_pend_q && wten_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_pend_q <= 1'b0;
      adj_pend_q   <= 1'b0;
      busy_o       <= 1'b0;
      kind_q       <= UPD_IDLE;
      left_q       <= '0;
    end else begin
      // a single flag: further carries while one is saved merge into it
      if (sec_evt_i)       carry_pend_q <= 1'b1;
      else if (start_step) carry_pend_q <= 1'b0;

      if (adj_req_i)       adj_pend_q <= 1'b1;
      else if (start_adj)  adj_pend_q <= 1'b0;

      if (start_adj) begin
        busy_o <= 1'b1;
        kind_q <= UPD_ADJ;
        left_q <= CW'(ADJ_TICKS);
      end else if (start_step) begin
        busy_o <= 1'b1;
        kind_q <= UPD_STEP;
        left_q <= CW'(CARRY_TICKS);
      end else if (busy_o && tick_i) begin
        if (left_q == CW'(1)) begin
          busy_o <= 1'b0;
          kind_q <= UPD_IDLE;
        end
        left_q <= left_q - CW'(1);
      end
    end
  end

  // R4: an allowed saved carry starts its window on the next clock
  a_r4_step_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && carry_pend_q && wten_i && !adj_pend_q) |=> (busy_o && kind_q == UPD_STEP));

  // R3: a pending adjustment takes precedence over a saved carry
  a_r3_adj_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && adj_pend_q) |=> (busy_o && kind_q == UPD_ADJ));

  // R2: a busy window always has ticks left to run
  a_r2_window_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (left_q != '0 && kind_q != UPD_IDLE));

  // R4: with updates held off no increment is applied
  a_r4_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !wten_i) |=> (kind_q != UPD_STEP));

endmodule

// File: rtl/rtc_sec_digits.sv
module rtc_sec_digits
  import rtc_sec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  input  logic       adj_i,
  output logic [7:0] sec_o,
  output logic       min_carry_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_o       <= 8'h00;
      min_carry_o <= 1'b0;
    end else begin
      min_carry_o <= 1'b0;
      if (load_i) begin
        sec_o <= load_val_i;
      end else if (step_i) begin
        sec_o       <= bcd_sec_next(sec_o);
        min_carry_o <= bcd_sec_at_top(sec_o);
      end else if (adj_i) begin
        sec_o       <= 8'h00;
        min_carry_o <= bcd_sec_rounds_up(sec_o);
      end
    end
  end

  // R1: a minute carry is only ever seen alongside 00
  a_r1_carry_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry_o |-> (sec_o == 8'h00));

  // R1: the value stays a legal BCD second (given legal host loads)
  a_r1_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7:4] <= 4'd5) && (sec_o[3:0] <= 4'd9));

  // R3: an adjustment always lands on 00
  a_r3_adj_zero: assert property (@(posedge clk) disable iff (!rst_n)
    adj_i |=> (sec_o == 8'h00));

endmodule

// File: rtl/rtc_sec_keeper.sv
module rtc_sec_keeper
  import rtc_sec_pkg::*;
#(
  parameter int unsigned PRESCALE    = 32768,
  parameter int unsigned CARRY_TICKS = 3,
  parameter int unsigned ADJ_TICKS   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       osc_run_i,
  input  logic       ce_i,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic       busy_o,
  output logic       wten_o,
  output logic       osc_stop_o,
  output logic       min_carry_o
);

  logic wr_ok;
  logic sec_wr;
  logic ctrl_wr;
  logic sec_load;
  logic adj_req;
  logic sec_evt;
  logic step_apply;
  logic adj_apply;

  assign wr_ok    = wr_i && ce_i;
  assign sec_wr   = wr_ok && (addr_i == ADDR_SEC);
  assign ctrl_wr  = wr_ok && (addr_i == ADDR_CTRL);
  assign sec_load = sec_wr && !busy_o;
  assign adj_req  = ctrl_wr && wdata_i[CTRL_ADJ_BIT];

  rtc_sec_prescale #(.PRESCALE(PRESCALE)) u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .sec_evt_o (sec_evt)
  );

  rtc_sec_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_i        (ce_i),
    .osc_run_i   (osc_run_i),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_wten_i (wdata_i[CTRL_WTEN_BIT]),
    .wten_o      (wten_o),
    .osc_stop_o  (osc_stop_o)
  );

  rtc_sec_seq #(
    .CARRY_TICKS (CARRY_TICKS),
    .ADJ_TICKS   (ADJ_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .sec_evt_i (sec_evt),
    .wten_i    (wten_o),
    .adj_req_i (adj_req),
    .busy_o    (busy_o),
    .step_o    (step_apply),
    .adj_o     (adj_apply)
  );

  rtc_sec_digits u_digits (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (sec_load),
    .load_val_i  (wdata_i),
    .step_i      (step_apply),
    .adj_i       (adj_apply),
    .sec_o       (sec_o),
    .min_carry_o (min_carry_o)
  );

  // R10: a seconds write during a busy window leaves the value alone
  a_r10_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && busy_o && !step_apply && !adj_apply) |=> $stable(sec_o));

  // R11: nothing written while deselected reaches the counter
  a_r11_deselected_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_i && !step_apply && !adj_apply) |=> $stable(sec_o));

  // R2: value changes only by load or by the end of a window
  a_r2_change_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_load && !step_apply && !adj_apply) |=> $stable(sec_o));

endmodule

// File: tb/rtc_sec_keeper_tb_top.sv
`timescale 1ns/1ps
module rtc_sec_keeper_tb_top;
  localparam int unsigned PRE  = 8;
  localparam int unsigned CART = 3;
  localparam int unsigned ADJT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       osc_run_i = 1'b1;
  logic       ce_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [3:0] addr_i = 4'h0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] sec_o;
  logic       busy_o;
  logic       wten_o;
  logic       osc_stop_o;
  logic       min_carry_o;

  int  n_checks = 0;
  int  n_fail = 0;
  int  mc_count = 0;
  int  busy_ticks = 0;
  int  cyc = 0;
  bit  run_ticks = 1'b0;
  bit  ph = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_sec_keeper #(.PRESCALE(PRE), .CARRY_TICKS(CART), .ADJ_TICKS(ADJT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_run_i(osc_run_i), .ce_i(ce_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .sec_o(sec_o), .busy_o(busy_o),
    .wten_o(wten_o), .osc_stop_o(osc_stop_o), .min_carry_o(min_carry_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // tick every other clock; count ticks the design consumes while busy
  initial forever begin
    @(negedge clk);
    ph = !ph;
    tick_i = run_ticks && ph;
    if (busy_o && tick_i) busy_ticks++;
    if (min_carry_o) mc_count++;
  end

  function automatic logic [7:0] to_bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!busy_o);
    do @(negedge clk); while (busy_o);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s0, mc0, t0, t1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(sec_o == 8'h00, "R12 sec", sec_o, 0);
    check(busy_o == 1'b0, "R12 busy", busy_o, 0);
    check(wten_o == 1'b1, "R12 wten", wten_o, 1);
    check(osc_stop_o == 1'b1, "R12 osc_stop", osc_stop_o, 1);

    // R9 clear with oscillator running
    do_write(4'hE, 8'h02);
    check(osc_stop_o == 1'b0, "R9 clear", osc_stop_o, 0);

    run_ticks = 1'b1;
    wait_done();
    t0 = cyc;
    s0 = sec_o;
    busy_ticks = 0;
    wait_done();
    t1 = cyc;
    check(sec_o == to_bcd(((s0 / 16) * 10 + s0 % 16 + 1) % 60), "R2 value", sec_o, 0);
    check(busy_ticks == CART, "R2 window", busy_ticks, CART);
    check((t1 - t0) == 2 * PRE, "R1 period", t1 - t0, 2 * PRE);

    // R1 sweep every value through one increment; R10 load when idle
    for (int v = 0; v < 60; v++) begin
      wait_done();
      do_write(4'h0, to_bcd(v));
      mc0 = mc_count;
      busy_ticks = 0;
      wait_done();
      check(sec_o == to_bcd((v + 1) % 60), "R1 step", sec_o, to_bcd((v + 1) % 60));
      check((mc_count - mc0) == ((v == 59) ? 1 : 0), "R1 carry", mc_count - mc0, (v == 59) ? 1 : 0);
      check(busy_ticks == CART, "R2 window", busy_ticks, CART);
    end

    // R3 sweep with updates held off
    do_write(4'hE, 8'h00);
    idle(12);
    for (int v = 0; v < 60; v++) begin
      do_write(4'h0, to_bcd(v));
      check(sec_o == to_bcd(v), "R10 load", sec_o, to_bcd(v));
      mc0 = mc_count;
      busy_ticks = 0;
      do_write(4'hE, 8'h01);
      wait_done();
      @(negedge clk);
      check(sec_o == 8'h00, "R3 zero", sec_o, 0);
      check(busy_ticks == ADJT, "R3 window", busy_ticks, ADJT);
      check((mc_count - mc0) == ((v >= 30) ? 1 : 0), "R3 carry", mc_count - mc0, (v >= 30) ? 1 : 0);
    end
    check(sec_o == 8'h00, "R4 held", sec_o, 0);

    // R10 write during busy is ignored
    do_write(4'h0, 8'h12);
    do_write(4'hE, 8'h01);
    @(negedge clk);
    check(busy_o == 1'b1, "R10 busy", busy_o, 1);
    do_write(4'h0, 8'h45);
    wait_done();
    check(sec_o == 8'h00, "R10 ignored", sec_o, 0);

    // R4 and R5: release after many held seconds gives one step
    busy_ticks = 0;
    do_write(4'hE, 8'h02);
    check(wten_o == 1'b1, "R6 load", wten_o, 1);
    @(negedge clk);
    check(busy_o == 1'b1, "R4 prompt", busy_o, 1);
    do @(negedge clk); while (busy_o);
    check(sec_o == 8'h01, "R5 single", sec_o, 1);
    check(busy_ticks == CART, "R4 window", busy_ticks, CART);

    // R6 ce low forces write-enable and releases a saved carry
    wait_done();
    do_write(4'hE, 8'h00);
    check(wten_o == 1'b0, "R6 cleared", wten_o, 0);
    idle(4 * PRE);
    s0 = sec_o;
    ce_i = 1'b0;
    @(negedge clk);
    check(wten_o == 1'b1, "R6 ce low", wten_o, 1);
    ce_i = 1'b1;
    wait_done();
    check(sec_o == to_bcd(((s0 / 16) * 10 + s0 % 16 + 1) % 60), "R4 release", sec_o, 0);

    // R11 write while deselected
    s0 = sec_o;
    ce_i = 1'b0;
    do_write(4'h0, 8'h33);
    ce_i = 1'b1;
    check(sec_o == s0[7:0], "R11 ignored", sec_o, s0);

    // R7, R8, R9 oscillator stop flag
    ce_i = 1'b0; osc_run_i = 1'b0;
    idle(4);
    check(osc_stop_o == 1'b1, "R7 set", osc_stop_o, 1);
    osc_run_i = 1'b1;
    idle(4);
    check(osc_stop_o == 1'b1, "R7 sticky", osc_stop_o, 1);
    ce_i = 1'b1; osc_run_i = 1'b0;
    do_write(4'hE, 8'h02);
    check(osc_stop_o == 1'b1, "R9 no clear", osc_stop_o, 1);
    osc_run_i = 1'b1;
    do_write(4'hE, 8'h02);
    check(osc_stop_o == 1'b0, "R9 clear", osc_stop_o, 0);
    osc_run_i = 1'b0;
    idle(10);
    check(osc_stop_o == 1'b0, "R8 hold", osc_stop_o, 0);
    osc_run_i = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule